// File: doc/BRIEF.md
# Wrapping Frame Buffer Address Tracker

This block follows where each new frame begins inside two circular image buffers, one for luma and one for chroma. A camera pipeline writes frames into these rings and a video encoder reads them back. Each plane has its own bottom and top offset and its own frame stride, so each plane wraps on its own. The encoder reads the next start address of each plane, an 8-bit frame id, the line count at the last progress point, and a flag that is raised when that line count has reached the number of lines the ring can hold.

A configuration is loaded with a single pulse. The block first derives four values with a shared iterative divider: lines per frame, lines per ring, the luma frame step modulo the luma ring, and the chroma frame step modulo the chroma ring. It then searches for the loop period, which is the number of frames after which the luma start offset returns to zero. `busy` is high during all of this work. After the setup, frame-end pulses advance the start addresses with one add and one conditional subtract per plane. Frame-start and the quarter, half and three-quarter progress pulses update only the reported line count.

Top module: `ring_frame_tracker`

## Requirements
- R1: After reset, `busy`, `cfg_err`, `overflow`, `frame_id`, `line_count` and both address outputs are all zero.
- R2: A configuration is rejected if either plane has top ≤ bottom, or if the luma line stride, the luma frame stride or the chroma frame stride is zero. A rejected configuration sets `cfg_err` to 1 one cycle after the load pulse, leaves `busy` low and changes nothing else. An accepted configuration clears `cfg_err`.
- R3: After an accepted load, `busy` stays high until setup finishes. When `busy` falls, each address equals base + bottom + ((1 mod L) × frame stride) mod (top − bottom) for its plane, `frame_id` is 0 and `line_count` is 0.
- R4: The loop period L is the smallest i in 1..LOOP_MAX−1 for which i × luma frame stride is a multiple of the luma ring size (top − bottom). If no such i exists, L is LOOP_MAX.
- R5: One cycle after the k-th frame-end pulse, each address equals base + bottom + ((k mod L) × frame stride) mod ring, and `frame_id` equals k mod 256.
- R6: One cycle after a progress pulse, `line_count` is M rounded up to a multiple of 32, where M depends on the pulse: 0 for frame start, M/4 for quarter, M/2 for half, (M/4)×3 for three-quarter, and M for frame end. Here M = luma frame stride / luma line stride, using integer division.
- R7: `overflow` is 1 exactly when a configuration is in force and `line_count` ≥ luma ring size / luma line stride.
- R8: Progress and frame-end pulses have no effect while `busy` is high or before any configuration has been accepted.
- R9: The chroma address uses the chroma bottom, top and frame stride. It returns to the chroma bottom whenever the frame index wraps to 0, even when the chroma ring alone would not yet have wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Pulse that loads the configuration inputs |
| cfg_base | input | AW | Base address of the shared buffer area |
| cfg_y_bot | input | OW | Luma ring bottom offset |
| cfg_y_top | input | OW | Luma ring top offset (exclusive) |
| cfg_y_line_stride | input | OW | Luma bytes per line |
| cfg_y_frame_stride | input | OW | Luma bytes per frame |
| cfg_c_bot | input | OW | Chroma ring bottom offset |
| cfg_c_top | input | OW | Chroma ring top offset (exclusive) |
| cfg_c_frame_stride | input | OW | Chroma bytes per frame |
| ev_frame_start | input | 1 | Frame-start pulse |
| ev_quarter | input | 1 | Quarter-frame progress pulse |
| ev_half | input | 1 | Half-frame progress pulse |
| ev_three_quarter | input | 1 | Three-quarter progress pulse |
| ev_frame_end | input | 1 | Frame-end pulse |
| busy | output | 1 | Setup after a load is in progress |
| cfg_err | output | 1 | Last load was rejected |
| next_y_addr | output | AW | Start address of the next luma frame |
| next_c_addr | output | AW | Start address of the next chroma frame |
| frame_id | output | 8 | Frame counter modulo 256 |
| line_count | output | OW+1 | Reported line count, a multiple of 32 |
| overflow | output | 1 | Line count has reached the ring capacity |

## Verification
The assertions assume that at most one progress or frame-end pulse is high in any cycle. They also assume that `cfg_base` plus the top offsets does not wrap the address width, so that the ring-bound checks compare plain integers. The stimulus drives every pulse alone for a single cycle, and it uses base addresses far below the top of the address space. Loads are issued only while the block is idle, apart from one deliberate frame-end pulse sent during setup to show that pulses are ignored while `busy` is high.

// File: rtl/rft_pkg.sv
package rft_pkg;

   typedef enum logic [2:0] {
      EV_NONE,
      EV_START,
      EV_Q1,
      EV_HALF,
      EV_Q3,
      EV_END
   } rft_event_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_DIV,
      ST_SEARCH
   } rft_state_e;

endpackage

// File: rtl/rft_divider.sv
// Restoring divider: produces one quotient bit per cycle, W cycles per operation.
module rft_divider #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         done,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   localparam int CW = $clog2(W + 1);

   if (W < 2) begin : g_bad_w
      $error("rft_divider: W must be at least 2");
   end

   logic [W-1:0] rem_r, quo_r, dvs_r;
   logic [CW-1:0] cnt;
   logic          run;
   logic [W:0]    shifted;
   logic          fits;

   always_comb begin
      shifted = {rem_r, quo_r[W-1]};
      fits    = (shifted >= {1'b0, dvs_r});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_r <= '0;
         quo_r <= '0;
         dvs_r <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            rem_r <= '0;
            quo_r <= dividend;
            dvs_r <= divisor;
            cnt   <= CW'(W);
            run   <= 1'b1;
         end else if (run) begin
            if (fits) begin
               rem_r <= W'(shifted - {1'b0, dvs_r});
               quo_r <= {quo_r[W-2:0], 1'b1};
            end else begin
               rem_r <= shifted[W-1:0];
               quo_r <= {quo_r[W-2:0], 1'b0};
            end
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign quo = quo_r;
   assign rem = rem_r;

   // Remainder must always be less than the divisor (supports R4/R5 step values)
   p_rem_below_divisor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rem_r < dvs_r));

endmodule

// File: rtl/rft_period_finder.sv
// Finds the smallest i with (i * step) mod ring == 0 by accumulating the step.
module rft_period_finder #(
   parameter int OW       = 16,
   parameter int LOOP_MAX = 65536,
   parameter int LCW      = $clog2(LOOP_MAX + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic [OW-1:0]  step,
   input  logic [OW-1:0]  ring,
   output logic           done,
   output logic [LCW-1:0] period
);
   if (LOOP_MAX < 2) begin : g_bad_loop
      $error("rft_period_finder: LOOP_MAX must be at least 2");
   end

   logic [OW-1:0]  acc;
   logic [LCW-1:0] idx;
   logic           run;
   logic [OW:0]    sum;

   always_comb begin
      sum = {1'b0, acc} + {1'b0, step};
      if (sum >= {1'b0, ring}) sum = sum - {1'b0, ring};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         idx    <= '0;
         run    <= 1'b0;
         done   <= 1'b0;
         period <= '0;
      end else begin
         done <= 1'b0;
         if (go) begin
            acc <= step;
            idx <= LCW'(1);
            run <= 1'b1;
         end else if (run) begin
            if (acc == '0) begin
               period <= idx;
               done   <= 1'b1;
               run    <= 1'b0;
            end else if (idx == LCW'(LOOP_MAX - 1)) begin
               period <= LCW'(LOOP_MAX);
               done   <= 1'b1;
               run    <= 1'b0;
            end else begin
               acc <= sum[OW-1:0];
               idx <= idx + LCW'(1);
            end
         end
      end
   end

   p_period_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (period != '0) && (period <= LCW'(LOOP_MAX)));

endmodule

// File: rtl/rft_line_marks.sv
// Maps a progress event to its line count, rounded up to a multiple of 32.
module rft_line_marks
   import rft_pkg::*;
#(
   parameter int OW = 16
) (
   input  logic [OW-1:0] max_lines,
   input  rft_event_e    ev,
   output logic [OW:0]   lines
);
   localparam int LW = OW + 1;

   if (OW < 6) begin : g_bad_ow
      $error("rft_line_marks: OW must be at least 6");
   end

   logic [LW-1:0] raw;
   logic [LW-1:0] quarter;

   always_comb begin
      quarter = LW'(max_lines >> 2);
      case (ev)
         EV_Q1:   raw = quarter;
         EV_HALF: raw = LW'(max_lines >> 1);
         EV_Q3:   raw = quarter * LW'(3);
         EV_END:  raw = LW'(max_lines);
         default: raw = '0;
      endcase
      lines = (raw + LW'(31)) & ~LW'(31);
   end

endmodule

// File: rtl/ring_frame_tracker.sv
module ring_frame_tracker
   import rft_pkg::*;
#(
   parameter int AW       = 32,
   parameter int OW       = 16,
   parameter int LOOP_MAX = 65536
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_load,
   input  logic [AW-1:0] cfg_base,
   input  logic [OW-1:0] cfg_y_bot,
   input  logic [OW-1:0] cfg_y_top,
   input  logic [OW-1:0] cfg_y_line_stride,
   input  logic [OW-1:0] cfg_y_frame_stride,
   input  logic [OW-1:0] cfg_c_bot,
   input  logic [OW-1:0] cfg_c_top,
   input  logic [OW-1:0] cfg_c_frame_stride,
   input  logic          ev_frame_start,
   input  logic          ev_quarter,
   input  logic          ev_half,
   input  logic          ev_three_quarter,
   input  logic          ev_frame_end,
   output logic          busy,
   output logic          cfg_err,
   output logic [AW-1:0] next_y_addr,
   output logic [AW-1:0] next_c_addr,
   output logic [7:0]    frame_id,
   output logic [OW:0]   line_count,
   output logic          overflow
);
   localparam int LW  = OW + 1;
   localparam int LCW = $clog2(LOOP_MAX + 1);

   if (AW < OW + 1) begin : g_bad_aw
      $error("ring_frame_tracker: AW must exceed OW");
   end
   if (OW < 6) begin : g_bad_ow
      $error("ring_frame_tracker: OW must be at least 6");
   end

   rft_state_e     state;
   logic [1:0]     op;
   logic           div_go, srch_go, cfg_valid, err_r;
   logic [AW-1:0]  r_base;
   logic [OW-1:0]  r_ybot, r_cbot, r_yring, r_cring;
   logic [OW-1:0]  r_ylstd, r_yfstd, r_cfstd;
   logic [OW-1:0]  r_maxl, r_wrap, r_ystep, r_cstep;
   logic [LCW-1:0] r_loop, n_idx;
   logic [OW-1:0]  y_off, c_off;
   logic [AW-1:0]  y_addr_r, c_addr_r;
   logic [7:0]     id_r;
   logic [LW-1:0]  lines_r;

   // ---------------- configuration check ----------------
   logic cfg_bad;
   assign cfg_bad = (cfg_y_top <= cfg_y_bot) || (cfg_c_top <= cfg_c_bot) ||
                    (cfg_y_line_stride == '0) || (cfg_y_frame_stride == '0) ||
                    (cfg_c_frame_stride == '0);

   // ---------------- event decode ----------------
   rft_event_e ev_code;
   logic       ev_acc;
   always_comb begin
      if (ev_frame_end)          ev_code = EV_END;
      else if (ev_three_quarter) ev_code = EV_Q3;
      else if (ev_half)          ev_code = EV_HALF;
      else if (ev_quarter)       ev_code = EV_Q1;
      else if (ev_frame_start)   ev_code = EV_START;
      else                       ev_code = EV_NONE;
   end
   assign ev_acc = (state == ST_IDLE) && cfg_valid && (ev_code != EV_NONE) && !cfg_load;

   // ---------------- shared divider ----------------
   logic [OW-1:0] div_dd, div_dv, div_q, div_r;
   logic          div_done;
   always_comb begin
      case (op)
         2'd0:    begin div_dd = r_yfstd; div_dv = r_ylstd; end
         2'd1:    begin div_dd = r_yring; div_dv = r_ylstd; end
         2'd2:    begin div_dd = r_yfstd; div_dv = r_yring; end
         default: begin div_dd = r_cfstd; div_dv = r_cring; end
      endcase
   end

   rft_divider #(.W(OW)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (div_go),
      .dividend (div_dd),
      .divisor  (div_dv),
      .done     (div_done),
      .quo      (div_q),
      .rem      (div_r)
   );

   // ---------------- loop period search ----------------
   logic           srch_done;
   logic [LCW-1:0] srch_period;
   rft_period_finder #(.OW(OW), .LOOP_MAX(LOOP_MAX), .LCW(LCW)) u_find (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (srch_go),
      .step   (r_ystep),
      .ring   (r_yring),
      .done   (srch_done),
      .period (srch_period)
   );

   // ---------------- line marks ----------------
   logic [LW-1:0] mark_lines;
   rft_line_marks #(.OW(OW)) u_marks (
      .max_lines (r_maxl),
      .ev        (ev_code),
      .lines     (mark_lines)
   );

   // ---------------- offset advance ----------------
   logic [OW:0]    y_sum, c_sum;
   logic [LCW-1:0] n_inc;
   logic           idx_wrap;
   always_comb begin
      y_sum = {1'b0, y_off} + {1'b0, r_ystep};
      if (y_sum >= {1'b0, r_yring}) y_sum = y_sum - {1'b0, r_yring};
      c_sum = {1'b0, c_off} + {1'b0, r_cstep};
      if (c_sum >= {1'b0, r_cring}) c_sum = c_sum - {1'b0, r_cring};
      n_inc    = n_idx + LCW'(1);
      idx_wrap = (n_inc == r_loop);
   end

   logic          one_loop;
   logic [OW-1:0] y_first, c_first;
   assign one_loop = (srch_period == LCW'(1));
   assign y_first  = one_loop ? '0 : r_ystep;
   assign c_first  = one_loop ? '0 : r_cstep;

   // ---------------- control ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         op        <= '0;
         div_go    <= 1'b0;
         srch_go   <= 1'b0;
         cfg_valid <= 1'b0;
         err_r     <= 1'b0;
         r_base    <= '0;
         r_ybot    <= '0;
         r_cbot    <= '0;
         r_yring   <= '0;
         r_cring   <= '0;
         r_ylstd   <= '0;
         r_yfstd   <= '0;
         r_cfstd   <= '0;
         r_maxl    <= '0;
         r_wrap    <= '0;
         r_ystep   <= '0;
         r_cstep   <= '0;
         r_loop    <= '0;
         n_idx     <= '0;
         y_off     <= '0;
         c_off     <= '0;
         y_addr_r  <= '0;
         c_addr_r  <= '0;
         id_r      <= '0;
         lines_r   <= '0;
      end else begin
         div_go  <= 1'b0;
         srch_go <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (cfg_load) begin
                  if (cfg_bad) begin
                     err_r <= 1'b1;
                  end else begin
                     err_r     <= 1'b0;
                     cfg_valid <= 1'b0;
                     r_base    <= cfg_base;
                     r_ybot    <= cfg_y_bot;
                     r_cbot    <= cfg_c_bot;
                     r_yring   <= cfg_y_top - cfg_y_bot;
                     r_cring   <= cfg_c_top - cfg_c_bot;
                     r_ylstd   <= cfg_y_line_stride;
                     r_yfstd   <= cfg_y_frame_stride;
                     r_cfstd   <= cfg_c_frame_stride;
                     op        <= 2'd0;
                     div_go    <= 1'b1;
                     state     <= ST_DIV;
                  end
               end else if (ev_acc) begin
                  lines_r <= mark_lines;
                  if (ev_code == EV_END) begin
                     id_r     <= id_r + 8'd1;
                     y_addr_r <= r_base + AW'(r_ybot) + AW'(y_off);
                     c_addr_r <= r_base + AW'(r_cbot) + AW'(c_off);
                     if (idx_wrap) begin
                        n_idx <= '0;
                        y_off <= '0;
                        c_off <= '0;
                     end else begin
                        n_idx <= n_inc;
                        y_off <= y_sum[OW-1:0];
                        c_off <= c_sum[OW-1:0];
                     end
                  end
               end
            end
            ST_DIV: begin
               if (div_done) begin
                  case (op)
                     2'd0:    r_maxl  <= div_q;
                     2'd1:    r_wrap  <= div_q;
                     2'd2:    r_ystep <= div_r;
                     default: r_cstep <= div_r;
                  endcase
                  if (op == 2'd3) begin
                     srch_go <= 1'b1;
                     state   <= ST_SEARCH;
                  end else begin
                     op     <= op + 2'd1;
                     div_go <= 1'b1;
                  end
               end
            end
            ST_SEARCH: begin
               if (srch_done) begin
                  r_loop    <= srch_period;
                  n_idx     <= one_loop ? '0 : LCW'(1);
                  y_off     <= y_first;
                  c_off     <= c_first;
                  y_addr_r  <= r_base + AW'(r_ybot) + AW'(y_first);
                  c_addr_r  <= r_base + AW'(r_cbot) + AW'(c_first);
                  id_r      <= '0;
                  lines_r   <= '0;
                  cfg_valid <= 1'b1;
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (state != ST_IDLE);
   assign cfg_err     = err_r;
   assign next_y_addr = y_addr_r;
   assign next_c_addr = c_addr_r;
   assign frame_id    = id_r;
   assign line_count  = lines_r;
   assign overflow    = cfg_valid && (lines_r >= LW'(r_wrap));

   // ---------------- assertions ----------------
   // Input assumption: one progress pulse at a time (R6)
   p_single_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_frame_start, ev_quarter, ev_half, ev_three_quarter, ev_frame_end}));

   p_err_not_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !busy);

   p_ready_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (frame_id == 8'd0) && (line_count == '0));

   p_y_in_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> (next_y_addr >= r_base + AW'(r_ybot)) &&
                    (next_y_addr <  r_base + AW'(r_ybot) + AW'(r_yring)));

   p_c_in_ring_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> (next_c_addr >= r_base + AW'(r_cbot)) &&
                    (next_c_addr <  r_base + AW'(r_cbot) + AW'(r_cring)));

   p_id_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_acc && ev_code == EV_END) |=> (frame_id == $past(frame_id) + 8'd1));

   p_line_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      line_count[4:0] == 5'd0);

   p_busy_holds_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$fell(busy)) |-> $stable(frame_id));

endmodule

// File: tb/ring_frame_tracker_bench.sv
module ring_frame_tracker_bench;
   localparam int AW = 32;
   localparam int OW = 16;
   localparam int NV = 4;

   // Stimulus and expected-result table
   localparam logic [31:0] T_BASE [NV] = '{32'h1000_0000, 32'h2000_0000, 32'h0000_8000, 32'h0001_0000};
   localparam int T_YBOT  [NV] = '{256,   0,    512, 7};
   localparam int T_YTOP  [NV] = '{3456,  640,  1024, 14};
   localparam int T_LSTD  [NV] = '{64,    16,   32,  1};
   localparam int T_YFSTD [NV] = '{1280,  1600, 512, 3};
   localparam int T_CBOT  [NV] = '{16384, 1000, 100, 50};
   localparam int T_CTOP  [NV] = '{17984, 1700, 400, 60};
   localparam int T_CFSTD [NV] = '{640,   300,  100, 4};
   localparam int T_LOOP  [NV] = '{5,     2,    1,   7};
   localparam int T_MAXL  [NV] = '{20,    100,  16,  3};
   localparam int T_WRAP  [NV] = '{50,    40,   16,  7};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_load = 1'b0;
   logic [AW-1:0] cfg_base = '0;
   logic [OW-1:0] cfg_y_bot = '0, cfg_y_top = '0, cfg_y_line_stride = '0, cfg_y_frame_stride = '0;
   logic [OW-1:0] cfg_c_bot = '0, cfg_c_top = '0, cfg_c_frame_stride = '0;
   logic ev_frame_start = 1'b0, ev_quarter = 1'b0, ev_half = 1'b0;
   logic ev_three_quarter = 1'b0, ev_frame_end = 1'b0;
   logic busy, cfg_err, overflow;
   logic [AW-1:0] next_y_addr, next_c_addr;
   logic [7:0] frame_id;
   logic [OW:0] line_count;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   ring_frame_tracker #(.AW(AW), .OW(OW), .LOOP_MAX(65536)) u_ring_frame_tracker (
      .clk, .rst_n, .cfg_load, .cfg_base, .cfg_y_bot, .cfg_y_top,
      .cfg_y_line_stride, .cfg_y_frame_stride, .cfg_c_bot, .cfg_c_top,
      .cfg_c_frame_stride, .ev_frame_start, .ev_quarter, .ev_half,
      .ev_three_quarter, .ev_frame_end, .busy, .cfg_err, .next_y_addr,
      .next_c_addr, .frame_id, .line_count, .overflow
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic longint addr_of(longint base, longint bot, longint top, longint fstd, longint idx);
      return base + bot + ((idx * fstd) % (top - bot));
   endfunction

   function automatic longint up32(longint x);
      return ((x + 31) / 32) * 32;
   endfunction

   task automatic load(input longint base, input int yb, input int yt, input int ls,
                       input int yf, input int cb, input int ct, input int cf);
      @(negedge clk);
      cfg_base = AW'(base);
      cfg_y_bot = OW'(yb); cfg_y_top = OW'(yt); cfg_y_line_stride = OW'(ls);
      cfg_y_frame_stride = OW'(yf); cfg_c_bot = OW'(cb); cfg_c_top = OW'(ct);
      cfg_c_frame_stride = OW'(cf);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic load_row(input int v);
      load(longint'(T_BASE[v]), T_YBOT[v], T_YTOP[v], T_LSTD[v], T_YFSTD[v],
           T_CBOT[v], T_CTOP[v], T_CFSTD[v]);
   endtask

   task automatic wait_ready();
      for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
   endtask

   // which: 0 start, 1 quarter, 2 half, 3 three-quarter, 4 end
   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: ev_frame_start = 1'b1;
         1: ev_quarter = 1'b1;
         2: ev_half = 1'b1;
         3: ev_three_quarter = 1'b1;
         default: ev_frame_end = 1'b1;
      endcase
      @(negedge clk);
      ev_frame_start = 1'b0; ev_quarter = 1'b0; ev_half = 1'b0;
      ev_three_quarter = 1'b0; ev_frame_end = 1'b0;
   endtask

   task automatic chk_addr(input string req, input int v, input longint idx);
      chk(req, "luma address", longint'(next_y_addr),
          addr_of(longint'(T_BASE[v]), T_YBOT[v], T_YTOP[v], T_YFSTD[v], idx));
      chk(req, "chroma address", longint'(next_c_addr),
          addr_of(longint'(T_BASE[v]), T_CBOT[v], T_CTOP[v], T_CFSTD[v], idx));
   endtask

   task automatic chk_lines(input string req, input int v, input longint raw);
      longint exp_l = up32(raw);
      chk(req, "line count", longint'(line_count), exp_l);
      chk("R7", "overflow", longint'(overflow), (exp_l >= T_WRAP[v]) ? 1 : 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "busy", longint'(busy), 0);
      chk("R1", "cfg_err", longint'(cfg_err), 0);
      chk("R1", "frame_id", longint'(frame_id), 0);
      chk("R1", "line_count", longint'(line_count), 0);
      chk("R1", "overflow", longint'(overflow), 0);
      chk("R1", "luma address", longint'(next_y_addr), 0);
      chk("R1", "chroma address", longint'(next_c_addr), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: pulses before any configuration
      pulse(4);
      chk("R8", "frame_id before config", longint'(frame_id), 0);
      pulse(2);
      chk("R8", "line_count before config", longint'(line_count), 0);

      // R2: rejected configurations
      load(32'h100, 10, 10, 4, 8, 0, 20, 4);
      chk("R2", "err on luma top==bot", longint'(cfg_err), 1);
      chk("R2", "busy on reject", longint'(busy), 0);
      load(32'h100, 0, 100, 0, 8, 0, 20, 4);
      chk("R2", "err on zero line stride", longint'(cfg_err), 1);
      load(32'h100, 0, 100, 4, 8, 30, 20, 4);
      chk("R2", "err on chroma top<bot", longint'(cfg_err), 1);
      load(32'h100, 0, 100, 4, 8, 0, 20, 0);
      chk("R2", "err on zero chroma stride", longint'(cfg_err), 1);
      chk("R2", "address unchanged after reject", longint'(next_y_addr), 0);

      // Table walk: R3 R4 R5 R6 R7 R9
      for (int v = 0; v < NV; v++) begin
         load_row(v);
         chk("R3", "busy after load", longint'(busy), 1);
         chk("R2", "err cleared by good load", longint'(cfg_err), 0);
         wait_ready();
         chk("R3", "busy after setup", longint'(busy), 0);
         chk_addr("R3", v, 1 % T_LOOP[v]);
         chk("R3", "frame_id after setup", longint'(frame_id), 0);
         pulse(0); chk_lines("R6", v, 0);
         pulse(1); chk_lines("R6", v, T_MAXL[v] / 4);
         pulse(2); chk_lines("R6", v, T_MAXL[v] / 2);
         pulse(3); chk_lines("R6", v, (T_MAXL[v] / 4) * 3);
         for (int k = 1; k <= 2 * T_LOOP[v] + 2; k++) begin
            pulse(4);
            chk_addr("R5", v, k % T_LOOP[v]);   // loop period from R4, chroma reset R9
            chk("R5", "frame_id", longint'(frame_id), k % 256);
            chk_lines("R6", v, T_MAXL[v]);
         end
      end

      // R8: frame end during busy is ignored
      load_row(0);
      pulse(4);
      wait_ready();
      chk("R8", "frame_id after busy pulse", longint'(frame_id), 0);
      chk_addr("R8", 0, 1);

      // R5: frame id wraps modulo 256
      for (int k = 1; k <= 260; k++) pulse(4);
      chk("R5", "frame_id wrap", longint'(frame_id), 260 % 256);
      chk_addr("R4", 0, 260 % T_LOOP[0]);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule